// File: doc/BRIEF.md
# Radix-8 Carry-Save SRT Significand Divider

This block divides one normalized fractional significand by another, three quotient bits per clock cycle. Each cycle it shifts the partial remainder left by three places and picks a quotient digit between -7 and +7 from a short estimate of that remainder and of the divisor. It then adds the negated digit multiple of the divisor. The multiple is never made by a multiplier. Each digit is split into at most two signed power-of-two terms, such as 8-1, 4+2, 4+1 or 4-1. Each term is a shifted and possibly inverted copy of the divisor, and both terms enter a two-level carry-save reduction. No carry has to ripple across the remainder inside the loop, so the cycle time does not grow with the operand width.

Both operands are unsigned W-bit integers with the top bit set, read as fractions d and x in [1/2, 1). The dividend is halved on entry, so the first remainder is below the divisor. Digits build the quotient through on-the-fly conversion, which keeps the quotient and the quotient minus one unit in the last place. After the last iteration the remainder is added up once. If it is negative, the minus-one form is returned. The result therefore is the exact truncated value of x/(2d) with QW = 3·ceil((W+1)/3) fractional bits, together with a flag telling whether the remainder was zero.

Operands enter on a valid/ready handshake and results leave on another one. The block holds one division at a time: input ready is high only while it is idle. A result stays on the output, unchanged, until the consumer takes it with output ready. The block then becomes idle on the following cycle.

Top module: `srt8_divider`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: An operand pair is taken on a rising edge where in_valid and in_ready are both 1. From the next cycle until the result has been handed over, in_ready is 0, and in_valid or operand changes in that span have no effect on the result.
- R3: quotient equals floor(dividend · 2^(QW-1) / divisor), with QW = 3·ceil((W+1)/3) (54 for W = 53). This is the truncated x/(2d) scaled by 2^QW.
- R4: rem_nonzero is 1 exactly when dividend · 2^(QW-1) is not a multiple of divisor.
- R5: out_valid first rises after the (N+1)th rising edge that follows the accepting edge, where N = ceil((W+1)/3).
- R6: While out_valid is 1 and out_ready is 0, out_valid, quotient and rem_nonzero keep their values into the next cycle. A result is handed over on an edge where out_valid and out_ready are both 1.
- R7: Quotient digits lie in -7..+7. Each digit multiple is formed from at most two signed, shifted divisor copies in carry-save form. The value of the partial remainder stays strictly between -d and +d in every iteration.
- R8: With the divisor at 1/2 (only the top bit set) and the dividend equal to the divisor, quotient is 2^(QW-1) and rem_nonzero is 0. Equal operands at the top of the range give the same result, and the extreme ratios follow R3.
- R9: For any normalized operands, quotient is at least 2^(QW-2) and below 2^QW, so its two top bits are never both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block idle and able to take operands |
| dividend | input | W | Dividend significand, top bit set |
| divisor | input | W | Divisor significand, top bit set |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| quotient | output | QW | Truncated quotient of x/(2d), QW fractional bits |
| rem_nonzero | output | 1 | Final remainder was not zero |

## Verification
Equal operands at 1/2 and at the top of the range must give exactly one half with a zero remainder. That separates a correct final correction from one that is off by a unit or that leaves a stray negative remainder. The extreme ratios, largest dividend over smallest divisor and the reverse, drive the digits to +7 and to low values and test both ends of the selection thresholds. Dividends one unit above or below the divisor produce long runs of negative or positive digits, which exercise the minus-one branch of the on-the-fly conversion. Random operands, taken with random output back-pressure while the input is kept busy with junk operands, cover the rest of the selection table, the holding of results and the ignoring of input while busy.

// File: rtl/srt8_pkg.sv
package srt8_pkg;

  // One signed power-of-two copy of the divisor: value = (neg ? -1 : +1) * (d << sh)
  typedef struct packed {
    logic       en;
    logic       neg;
    logic [1:0] sh;
  } term_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_FIX  = 2'd2,
    S_DONE = 2'd3
  } state_t;

  // Number of power-of-two terms a radix-8 digit needs at most
  localparam int NTERMS = 2;

endpackage

// File: rtl/srt8_select.sv
// Quotient digit selection from truncated remainder and divisor heads.
// Estimate y: 5 integer + 4 fraction bits, divisor head: 6 fraction bits.
// Digit k is the count of thresholds (j + 1/2) * dt that y reaches, minus 7.
module srt8_select (
  input  logic signed [8:0] est_sum,
  input  logic signed [8:0] est_car,
  input  logic        [5:0] d_head,
  output logic signed [3:0] digit
);
  logic signed [8:0] y;
  int yv;
  int dv;
  int cnt;

  assign y = est_sum + est_car;

  always_comb begin
    yv  = int'(y) <<< 3;          // y in units of 1/128
    dv  = int'({1'b0, d_head});   // dt in units of 1/64
    cnt = 0;
    for (int j = -7; j <= 6; j++) begin
      if (yv >= (2 * j + 1) * dv) cnt = cnt + 1;
    end
    digit = 4'(cnt - 7);
  end
endmodule

// File: rtl/srt8_recode.sv
// Splits a digit in -7..7 into up to two signed power-of-two terms that
// together equal -digit * d (the amount added to the shifted remainder).
module srt8_recode
  import srt8_pkg::*;
(
  input  logic signed [3:0] digit,
  output term_t             terms [NTERMS]
);
  logic       nd;
  logic [2:0] mag;

  assign nd  = digit[3];
  assign mag = nd ? 3'(-digit) : digit[2:0];

  always_comb begin
    terms[0] = '0;
    terms[1] = '0;
    unique case (mag)
      3'd7: begin terms[0] = '{1'b1, !nd, 2'd3}; terms[1] = '{1'b1,  nd, 2'd0}; end
      3'd6: begin terms[0] = '{1'b1, !nd, 2'd2}; terms[1] = '{1'b1, !nd, 2'd1}; end
      3'd5: begin terms[0] = '{1'b1, !nd, 2'd2}; terms[1] = '{1'b1, !nd, 2'd0}; end
      3'd4: begin terms[0] = '{1'b1, !nd, 2'd2}; end
      3'd3: begin terms[0] = '{1'b1, !nd, 2'd2}; terms[1] = '{1'b1,  nd, 2'd0}; end
      3'd2: begin terms[0] = '{1'b1, !nd, 2'd1}; end
      3'd1: begin terms[0] = '{1'b1, !nd, 2'd0}; end
      default: ;
    endcase
  end
endmodule

// File: rtl/srt8_csa_step.sv
// Adds the recoded divisor terms to a remainder held as sum/carry through
// one 3:2 level per term. The +1 of each inverted term goes into the free
// low bit of that level's carry vector.
module srt8_csa_step
  import srt8_pkg::*;
#(
  parameter int RW = 59
) (
  input  logic [RW-1:0] in_sum,
  input  logic [RW-1:0] in_car,
  input  logic [RW-1:0] dext,
  input  term_t         terms [NTERMS],
  output logic [RW-1:0] out_sum,
  output logic [RW-1:0] out_car
);
  logic [RW-1:0] s [NTERMS+1];
  logic [RW-1:0] c [NTERMS+1];

  assign s[0] = in_sum;
  assign c[0] = in_car;

  for (genvar t = 0; t < NTERMS; t++) begin : g_level
    logic [RW-1:0] shifted;
    logic [RW-1:0] opnd;
    assign shifted = dext << terms[t].sh;
    assign opnd    = !terms[t].en ? '0 : (terms[t].neg ? ~shifted : shifted);
    assign s[t+1]  = s[t] ^ c[t] ^ opnd;
    assign c[t+1]  = {(s[t][RW-2:0] & c[t][RW-2:0]) |
                      (s[t][RW-2:0] & opnd[RW-2:0]) |
                      (c[t][RW-2:0] & opnd[RW-2:0]),
                      terms[t].en & terms[t].neg};
  end

  assign out_sum = s[NTERMS];
  assign out_car = c[NTERMS];
endmodule

// File: rtl/srt8_otf.sv
// On-the-fly conversion of signed radix-8 digits into a binary quotient,
// keeping Q and Q - 1 ulp so that no carry chain follows a negative digit.
module srt8_otf #(
  parameter int QW = 54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic signed [3:0] digit,
  output logic [QW-1:0]     q,
  output logic [QW-1:0]     qm
);
  logic [3:0] dm1;
  assign dm1 = digit - 4'sd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q  <= '0;
      qm <= '1;
    end else if (clear) begin
      q  <= '0;
      qm <= '1;
    end else if (step) begin
      q  <= digit[3]      ? {qm[QW-4:0], digit[2:0]} : {q[QW-4:0], digit[2:0]};
      qm <= (digit > 4'sd0) ? {q[QW-4:0], dm1[2:0]}  : {qm[QW-4:0], dm1[2:0]};
    end
  end
endmodule

// File: rtl/srt8_divider.sv
// Radix-8 SRT divider for normalized significands, digits -7..+7.
module srt8_divider
  import srt8_pkg::*;
#(
  parameter int W = 53
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [W-1:0]                dividend,
  input  logic [W-1:0]                divisor,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [3*((W+3)/3)-1:0]      quotient,
  output logic                        rem_nonzero
);
  localparam int N  = (W + 3) / 3;      // iterations
  localparam int QW = 3 * N;            // quotient bits
  localparam int RW = W + 6;            // 5 integer bits + W+1 fraction bits
  localparam int CW = $clog2(N + 1);

  state_t          state;
  logic [CW-1:0]   iter;
  logic [RW-1:0]   ps, pc, dext;
  logic [5:0]      d_head;
  logic [RW-1:0]   ws, wc, ns, nc;
  logic [RW-1:0]   rem_sum;
  logic signed [3:0] digit;
  term_t           terms [NTERMS];
  logic [QW-1:0]   q_acc, qm_acc;
  logic            accept;

  assign accept    = in_valid && in_ready;
  assign in_ready  = (state == S_IDLE);
  assign out_valid = (state == S_DONE);

  // Shifted remainder (mod 2^RW keeps the sum exact while |8w| < 16)
  assign ws = ps << 3;
  assign wc = pc << 3;

  srt8_select u_sel (
    .est_sum (ws[RW-1 -: 9]),
    .est_car (wc[RW-1 -: 9]),
    .d_head  (d_head),
    .digit   (digit)
  );

  srt8_recode u_rec (
    .digit (digit),
    .terms (terms)
  );

  srt8_csa_step #(.RW(RW)) u_csa (
    .in_sum  (ws),
    .in_car  (wc),
    .dext    (dext),
    .terms   (terms),
    .out_sum (ns),
    .out_car (nc)
  );

  srt8_otf #(.QW(QW)) u_otf (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .step  (state == S_RUN),
    .digit (digit),
    .q     (q_acc),
    .qm    (qm_acc)
  );

  // Single assimilation, used once after the loop
  assign rem_sum = ps + pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      iter        <= '0;
      ps          <= '0;
      pc          <= '0;
      dext        <= '0;
      d_head      <= '0;
      quotient    <= '0;
      rem_nonzero <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (in_valid) begin
          ps     <= {6'b0, dividend};          // x/2
          pc     <= '0;
          dext   <= {5'b0, divisor, 1'b0};     // d
          d_head <= divisor[W-1 -: 6];
          iter   <= '0;
          state  <= S_RUN;
        end
        S_RUN: begin
          ps   <= ns;
          pc   <= nc;
          iter <= iter + 1'b1;
          if (iter == CW'(N - 1)) state <= S_FIX;
        end
        S_FIX: begin
          quotient    <= rem_sum[RW-1] ? qm_acc : q_acc;
          rem_nonzero <= |rem_sum;
          state       <= S_DONE;
        end
        S_DONE: if (out_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srt8_divider_chk.sv
module srt8_divider_chk #(
  parameter int W = 53
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [3*((W+3)/3)-1:0] quotient,
  input logic                   rem_nonzero,
  input logic                   looping,
  input logic [W+5:0]           rem_sum,
  input logic [W+5:0]           dext
);
  localparam int N  = (W + 3) / 3;
  localparam int QW = 3 * N;

  int lat;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat <= 0;
    else if (in_valid && in_ready) lat <= 0;
    else if (lat < N + 8) lat <= lat + 1;
  end

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R5
  result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat == N + 1));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(quotient) && $stable(rem_nonzero)));

  // R7
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    looping |-> (($signed(rem_sum) < $signed(dext)) && ($signed(rem_sum) > -$signed(dext))));

  // R9
  quot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (quotient[QW-1 -: 2] != 2'b00));
endmodule

bind srt8_divider srt8_divider_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .quotient    (quotient),
  .rem_nonzero (rem_nonzero),
  .looping     ((state == srt8_pkg::S_RUN) || (state == srt8_pkg::S_FIX)),
  .rem_sum     (rem_sum),
  .dext        (dext)
);

// File: tb/srt8_divider_test.sv
module srt8_divider_test;
  localparam int W  = 53;
  localparam int N  = (W + 3) / 3;
  localparam int QW = 3 * N;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          out_ready = 1'b0;
  logic [W-1:0]  dvd = '0;
  logic [W-1:0]  dvs = '0;
  logic          in_ready;
  logic          out_valid;
  logic [QW-1:0] quo;
  logic          nz;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [QW-1:0] exp_q  [$];
  logic          exp_nz [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  srt8_divider #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .dividend(dvd), .divisor(dvs), .out_valid(out_valid), .out_ready(out_ready),
    .quotient(quo), .rem_nonzero(nz)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [QW-1:0] act, input logic [QW-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic reference(input logic [W-1:0] x, input logic [W-1:0] d,
                           output logic [QW-1:0] q, output logic r);
    logic [W+QW-1:0] num, den, qq;
    num = (W + QW)'(x) << (QW - 1);
    den = (W + QW)'(d);
    qq  = num / den;
    q   = qq[QW-1:0];
    r   = (num % den) != 0;
  endtask

  // Driver: present operands, push expectation, keep input busy with junk
  task automatic send(input logic [W-1:0] x, input logic [W-1:0] d);
    logic [QW-1:0] eq;
    logic          er;
    int lat;
    reference(x, d, eq, er);
    @(negedge clk);
    in_valid = 1'b1; dvd = x; dvs = d;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    exp_q.push_back(eq);
    exp_nz.push_back(er);
    @(negedge clk);
    dvd = ~x | (W'(1) << (W - 1));
    dvs = {1'b1, {(W-1){1'b0}}};
    // R2: no second acceptance while busy
    check(in_ready == 1'b0, "R2", "in_ready while busy", QW'(in_ready), '0);
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
    end while (!out_valid && lat < 4 * N);
    in_valid = 1'b0;
    // R5
    check(lat == N + 1, "R5", "latency", QW'(lat), QW'(N + 1));
    wait (exp_q.size() == 0);
  endtask

  // Back-pressure source, changed just after each rising edge
  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #1 out_ready = ($urandom() % 3) != 0;
    end
  end

  // Monitor / scoreboard
  logic          held = 1'b0;
  logic [QW-1:0] held_q;
  logic          held_nz;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        // R6
        check(out_valid && quo == held_q && nz == held_nz, "R6",
              "result held under back-pressure", quo, held_q);
      end
      held = out_valid && !out_ready;
      held_q = quo;
      held_nz = nz;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "unexpected result", quo, '0);
        end else begin
          // R3
          check(quo == exp_q[0], "R3", "quotient", quo, exp_q[0]);
          // R4
          check(nz == exp_nz[0], "R4", "rem_nonzero", QW'(nz), QW'(exp_nz[0]));
          // R9
          check(quo[QW-1 -: 2] != 2'b00, "R9", "quotient range", quo, exp_q[0]);
          void'(exp_q.pop_front());
          void'(exp_nz.pop_front());
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] dmin, dmax, x, d;
    logic [QW-1:0] eq;
    logic          er;
    dmin = {1'b1, {(W-1){1'b0}}};
    dmax = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check(in_ready == 1'b1, "R1", "in_ready in reset", QW'(in_ready), QW'(1));
    check(out_valid == 1'b0, "R1", "out_valid in reset", QW'(out_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1", "idle after reset",
          QW'({in_ready, out_valid}), QW'(2));

    // R8: reference values for the corner cases
    reference(dmin, dmin, eq, er);
    check(eq == (QW'(1) << (QW - 1)) && !er, "R8", "reference half", eq, QW'(1) << (QW - 1));
    send(dmin, dmin);
    send(dmax, dmax);
    send(dmax, dmin);
    send(dmin, dmax);
    // R7: long runs of negative and positive digits
    send(dmin + W'(1), dmin);
    send(dmax - W'(1), dmax);
    send(dmin, dmin + W'(1));
    send(dmax, dmax - W'(1));

    for (int i = 0; i < 40; i++) begin
      x = W'({$urandom(), $urandom()}); x[W-1] = 1'b1;
      d = W'({$urandom(), $urandom()}); d[W-1] = 1'b1;
      if (i % 8 == 0) d = dmin;
      if (i % 8 == 1) x = d;
      send(x, d);
    end

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R3", "results outstanding", QW'(exp_q.size()), '0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule